// File: doc/BRIEF.md
# Two-Stage Adaptive Output Selector

This block picks an output port for a packet that is allowed to route adaptively in a router built as a grid of tiles. Each tile sits on one column and one row. A routing table supplies a mask of every output port the packet may use. The block folds that mask into one eligibility bit per column. In the first stage it picks a column, preferring columns whose row buffer is below half capacity. In the second stage it picks an output row inside that column from the row bits that travel with the packet. That stage prefers rows whose column buffer is nearly empty, then rows that are half full, then rows that are nearly full. Ties in either stage go to the first candidate at or after a rotating pointer. Each stage has its own pointer.

The block is run by a small controller with four states. ST_IDLE waits for a request and captures the port mask. ST_COLUMN runs the column choice against the row-buffer depths. ST_ROW runs the row choice against the column-buffer depths. ST_OFFER presents the result until the consumer answers.

The transitions are:
- ST_IDLE goes to ST_COLUMN when a request arrives.
- ST_COLUMN goes to ST_ROW when at least one column is eligible.
- ST_COLUMN goes straight to ST_OFFER, with a no-route result, when no column is eligible.
- ST_ROW goes to ST_OFFER after one cycle.
- ST_OFFER goes back to ST_IDLE on take or on drop. Only a take of a valid grant moves the pointers.

Top module: `adp_out_sel`

## Requirements
- R1: Port p lies in column p / 8 and row p % 8, so mask bit c*8+r is column c, row r. Column c is eligible exactly when any of its eight port bits is set.
- R2: Column c counts as uncongested when its row-buffer depth (5 bits, field c*5 of `row_depth_i`) is below 8. If any eligible column is uncongested, only uncongested eligible columns are candidates. Otherwise all eligible columns are candidates.
- R3: Among the column candidates, the winner is the first index at or after the column pointer, counting upward and wrapping from 7 to 0.
- R4: `row_mask_o` equals the eight mask bits of the chosen column, with bit r standing for row r.
- R5: Each row has a column-buffer depth (4 bits, field r*4 of `col_depth_i`). Depth 8 or more is almost full, 4 to 7 is half full, and 0 to 3 is almost empty. Among rows set in the row mask, the least-full non-empty class forms the candidate set.
- R6: Among the row candidates, the winner is the first index at or after the row pointer, wrapping.
- R7: Taking a valid grant sets each pointer to one past its chosen index, wrapping. A drop, or a take of a no-route result, leaves both pointers unchanged.
- R8: An all-zero port mask yields `res_none_o` high and `res_valid_o` low.
- R9: The result appears in ST_OFFER and holds until take or drop. A request while the block is not in ST_IDLE is ignored.
- R10: After reset both pointers are 0, the block is in ST_IDLE, and both result flags are low.
- R11: The number of eligible ports within a column has no bearing on the column choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request; sampled only in ST_IDLE |
| port_mask_i | input | 64 | Allowed output ports from the routing table |
| row_depth_i | input | 40 | Eight 5-bit row-buffer depths, one per column |
| col_depth_i | input | 32 | Eight 4-bit column-buffer depths, one per row |
| take_i | input | 1 | Consumer accepts the offered result |
| drop_i | input | 1 | Consumer discards the offered result |
| res_valid_o | output | 1 | A grant is offered |
| res_none_o | output | 1 | The request had no eligible port |
| col_sel_o | output | 3 | Chosen column |
| row_mask_o | output | 8 | Row bits that travel with the packet |
| row_sel_o | output | 3 | Chosen output row |

## Verification
On every cycle the assertions check the following:
- an offered grant names a port that was set in the captured mask;
- the chosen row lies inside the row mask;
- a no-route result comes only from an empty mask, and never together with a grant;
- the captured mask stays frozen while a request is in flight;
- a congested column is never picked while an uncongested eligible one exists;
- the pointers move only on a taken grant, and then to one past the winner.

Some behaviours only the bench scenarios can show. These are the exact round-robin order and the class ordering of rows, compared with an independent model. They also include the equal share each column receives over a long run, and the fact that a drop lets the same request be granted identically again.

// File: rtl/adp_pkg.sv
package adp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLUMN,
        ST_ROW,
        ST_OFFER
    } adp_state_e;

    typedef enum logic [1:0] {
        CLS_EMPTY,
        CLS_HALF,
        CLS_FULL
    } adp_class_e;

endpackage

// File: rtl/adp_col_reduce.sv
module adp_col_reduce #(
    parameter int NCOL = 8,
    parameter int NROW = 8
) (
    input  logic [NCOL*NROW-1:0] port_mask,
    output logic [NCOL-1:0]      col_mask
);

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        assign col_mask[c] = |port_mask[c*NROW +: NROW];
    end

endmodule

// File: rtl/adp_rr_pick.sv
module adp_rr_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0]         cand,
    input  logic [$clog2(N)-1:0] ptr,
    output logic [$clog2(N)-1:0] pick,
    output logic                 any
);

    localparam int W = $clog2(N);

    logic [W-1:0] probe;

    // Scan offsets from the far end down to 0 so that the nearest
    // candidate at or after the pointer is the one left in pick.
    always_comb begin
        any   = |cand;
        pick  = '0;
        probe = '0;
        for (int i = N - 1; i >= 0; i--) begin
            probe = W'((int'(ptr) + i) % N);
            if (cand[probe]) begin
                pick = probe;
            end
        end
    end

endmodule

// File: rtl/adp_out_sel.sv
module adp_out_sel
    import adp_pkg::*;
#(
    parameter int NCOL    = 8,
    parameter int NROW    = 8,
    parameter int RB_W    = 5,
    parameter int CB_W    = 4,
    parameter int RB_HALF = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid_i,
    input  logic [NCOL*NROW-1:0]      port_mask_i,
    input  logic [NCOL*RB_W-1:0]      row_depth_i,
    input  logic [NROW*CB_W-1:0]      col_depth_i,
    input  logic                      take_i,
    input  logic                      drop_i,
    output logic                      res_valid_o,
    output logic                      res_none_o,
    output logic [$clog2(NCOL)-1:0]   col_sel_o,
    output logic [NROW-1:0]           row_mask_o,
    output logic [$clog2(NROW)-1:0]   row_sel_o
);

    localparam int CW      = $clog2(NCOL);
    localparam int RW      = $clog2(NROW);
    localparam int CB_FULL = 1 << (CB_W - 1);
    localparam int CB_HALF = 1 << (CB_W - 2);

    adp_state_e              state_q, state_d;
    logic [NCOL*NROW-1:0]    mask_q;
    logic [CW-1:0]           col_q, col_ptr_q;
    logic [RW-1:0]           row_q, row_ptr_q;
    logic [NROW-1:0]         rmask_q;
    logic                    found_q;

    // ---------------- stage one: column choice ----------------
    logic [NCOL-1:0] col_mask;
    logic [NCOL-1:0] col_busy;
    logic [NCOL-1:0] col_pref;
    logic [NCOL-1:0] col_cand;
    logic [CW-1:0]   col_pick;
    logic            col_any;

    adp_col_reduce #(.NCOL(NCOL), .NROW(NROW)) u_reduce (
        .port_mask (mask_q),
        .col_mask  (col_mask)
    );

    for (genvar c = 0; c < NCOL; c++) begin : g_busy
        assign col_busy[c] = int'(row_depth_i[c*RB_W +: RB_W]) >= RB_HALF;
    end

    assign col_pref = col_mask & ~col_busy;
    assign col_cand = (|col_pref) ? col_pref : col_mask;

    adp_rr_pick #(.N(NCOL)) u_col_rr (
        .cand (col_cand),
        .ptr  (col_ptr_q),
        .pick (col_pick),
        .any  (col_any)
    );

    // ---------------- stage two: row choice ----------------
    adp_class_e      row_cls [NROW];
    logic [NROW-1:0] row_emp, row_half, row_full;
    logic [NROW-1:0] row_cand;
    logic [RW-1:0]   row_pick;
    logic            row_any;

    for (genvar r = 0; r < NROW; r++) begin : g_cls
        always_comb begin
            if (int'(col_depth_i[r*CB_W +: CB_W]) >= CB_FULL) begin
                row_cls[r] = CLS_FULL;
            end else if (int'(col_depth_i[r*CB_W +: CB_W]) >= CB_HALF) begin
                row_cls[r] = CLS_HALF;
            end else begin
                row_cls[r] = CLS_EMPTY;
            end
        end
        assign row_emp[r]  = rmask_q[r] && (row_cls[r] == CLS_EMPTY);
        assign row_half[r] = rmask_q[r] && (row_cls[r] == CLS_HALF);
        assign row_full[r] = rmask_q[r] && (row_cls[r] == CLS_FULL);
    end

    always_comb begin
        if (|row_emp) begin
            row_cand = row_emp;
        end else if (|row_half) begin
            row_cand = row_half;
        end else begin
            row_cand = row_full;
        end
    end

    adp_rr_pick #(.N(NROW)) u_row_rr (
        .cand (row_cand),
        .ptr  (row_ptr_q),
        .pick (row_pick),
        .any  (row_any)
    );

    // ---------------- controller ----------------
    logic grant_taken;
    assign grant_taken = (state_q == ST_OFFER) && found_q && take_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid_i) state_d = ST_COLUMN;
            ST_COLUMN: state_d = col_any ? ST_ROW : ST_OFFER;
            ST_ROW:    state_d = ST_OFFER;
            ST_OFFER:  if (take_i || drop_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q    <= '0;
            col_q     <= '0;
            row_q     <= '0;
            rmask_q   <= '0;
            found_q   <= 1'b0;
            col_ptr_q <= '0;
            row_ptr_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid_i) mask_q <= port_mask_i;
                end
                ST_COLUMN: begin
                    col_q   <= col_pick;
                    rmask_q <= mask_q[col_pick*NROW +: NROW];
                    found_q <= col_any;
                end
                ST_ROW: begin
                    row_q <= row_pick;
                end
                ST_OFFER: begin
                    if (grant_taken) begin
                        col_ptr_q <= CW'((int'(col_q) + 1) % NCOL);
                        row_ptr_q <= RW'((int'(row_q) + 1) % NROW);
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        res_valid_o = (state_q == ST_OFFER) && found_q;
        res_none_o  = (state_q == ST_OFFER) && !found_q;
        col_sel_o   = col_q;
        row_sel_o   = row_q;
        row_mask_o  = rmask_q;
    end

    // ---------------- assertions ----------------
    AST_GRANT_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> mask_q[int'(col_sel_o)*NROW + int'(row_sel_o)]); // R1

    AST_COL_PREF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLUMN && |col_pref) |-> !col_busy[col_pick]); // R2

    AST_ROW_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> row_mask_o[row_sel_o]); // R5

    AST_ROW_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ROW) |-> row_any); // R4

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_taken |=> ($stable(col_ptr_q) && $stable(row_ptr_q))); // R7

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        grant_taken |=> (int'(col_ptr_q) == (int'($past(col_sel_o)) + 1) % NCOL)); // R7

    AST_NONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        res_none_o |-> (mask_q == '0)); // R8

    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid_o && res_none_o)); // R8

    AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(mask_q)); // R9

endmodule

// File: tb/adp_out_sel_tb.sv
module adp_out_sel_tb;

    typedef struct {
        bit       none;
        int       col;
        int       row;
        bit [7:0] rmask;
        string    tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [63:0] port_mask_i = '0;
    logic [39:0] row_depth_i = '0;
    logic [31:0] col_depth_i = '0;
    logic        take_i = 1'b0;
    logic        drop_i = 1'b0;
    logic        res_valid_o, res_none_o;
    logic [2:0]  col_sel_o, row_sel_o;
    logic [7:0]  row_mask_o;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];
    int   m_cp = 0;
    int   m_rp = 0;
    int   col_hits[8];
    bit   seen = 1'b0;

    always #5 clk = ~clk;

    adp_out_sel u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .port_mask_i (port_mask_i),
        .row_depth_i (row_depth_i),
        .col_depth_i (col_depth_i),
        .take_i      (take_i),
        .drop_i      (drop_i),
        .res_valid_o (res_valid_o),
        .res_none_o  (res_none_o),
        .col_sel_o   (col_sel_o),
        .row_mask_o  (row_mask_o),
        .row_sel_o   (row_sel_o)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rr(bit [7:0] cand, int ptr);
        for (int i = 0; i < 8; i++) begin
            if (cand[(ptr + i) % 8]) return (ptr + i) % 8;
        end
        return -1;
    endfunction

    function automatic exp_t model(bit [63:0] m, bit [39:0] rd, bit [31:0] cd, string tag);
        exp_t     e;
        bit [7:0] cm, pref, e0, e1, e2, rc;
        e.tag = tag;
        e.col = 0;
        e.row = 0;
        e.rmask = '0;
        for (int c = 0; c < 8; c++) begin
            cm[c]   = (m[c*8 +: 8] != 0);
            pref[c] = cm[c] && (rd[c*5 +: 5] < 8);
        end
        e.none = (cm == 0);
        if (e.none) return e;
        e.col   = rr((pref != 0) ? pref : cm, m_cp);
        e.rmask = m[e.col*8 +: 8];
        for (int r = 0; r < 8; r++) begin
            e0[r] = e.rmask[r] && (cd[r*4 +: 4] < 4);
            e1[r] = e.rmask[r] && (cd[r*4 +: 4] >= 4) && (cd[r*4 +: 4] < 8);
            e2[r] = e.rmask[r] && (cd[r*4 +: 4] >= 8);
        end
        rc    = (e0 != 0) ? e0 : ((e1 != 0) ? e1 : e2);
        e.row = rr(rc, m_rp);
        return e;
    endfunction

    // Monitor: pops one expected item per offered result.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if ((res_valid_o || res_none_o) && !seen) begin
                exp_t e;
                seen = 1'b1;
                if (sb_q.size() == 0) begin
                    check(0, "R9 unexpected result", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    check(res_none_o == e.none, {e.tag, " none"}, res_none_o, e.none);
                    check(res_valid_o == !e.none, {e.tag, " valid"}, res_valid_o, !e.none);
                    if (!e.none) begin
                        check(col_sel_o == e.col, {e.tag, " column"}, col_sel_o, e.col);
                        check(row_sel_o == e.row, {e.tag, " row"}, row_sel_o, e.row);
                        check(row_mask_o == e.rmask, {e.tag, " R4 row mask"}, row_mask_o, e.rmask);
                        col_hits[col_sel_o]++;
                    end
                end
            end else if (!(res_valid_o || res_none_o)) begin
                seen = 1'b0;
            end
        end
    end

    // Driver: pushes the expected item, then runs one request.
    task automatic run(bit [63:0] m, bit [39:0] rd, bit [31:0] cd,
                       bit use_drop, bit noisy, string tag);
        exp_t e;
        int   wait_n;
        e = model(m, rd, cd, tag);
        sb_q.push_back(e);
        @(negedge clk);
        port_mask_i = m;
        row_depth_i = rd;
        col_depth_i = cd;
        req_valid_i = 1'b1;
        @(negedge clk);
        if (noisy) begin
            port_mask_i = ~m;
            @(negedge clk);
        end
        req_valid_i = 1'b0;
        port_mask_i = '0;
        wait_n = 0;
        while (!(res_valid_o || res_none_o) && wait_n < 10) begin
            @(negedge clk);
            #1;
            wait_n++;
        end
        check(res_valid_o || res_none_o, {tag, " R9 result arrives"}, 0, 1);
        repeat (2) begin
            @(negedge clk);
            #1;
            check(res_valid_o == !e.none, {tag, " R9 result held"}, res_valid_o, !e.none);
        end
        if (use_drop) drop_i = 1'b1;
        else          take_i = 1'b1;
        @(negedge clk);
        #1;
        take_i = 1'b0;
        drop_i = 1'b0;
        if (!use_drop && !e.none) begin
            m_cp = (e.col + 1) % 8;
            m_rp = (e.row + 1) % 8;
        end
    endtask

    function automatic bit [39:0] rd_all(int v);
        bit [39:0] x;
        for (int c = 0; c < 8; c++) x[c*5 +: 5] = 5'(v);
        return x;
    endfunction

    function automatic bit [31:0] cd_all(int v);
        bit [31:0] x;
        for (int r = 0; r < 8; r++) x[r*4 +: 4] = 4'(v);
        return x;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit [39:0] rd;
        bit [31:0] cd;
        repeat (3) @(negedge clk);
        #1;
        check(!res_valid_o && !res_none_o, "R10 reset flags", res_valid_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!res_valid_o && !res_none_o, "R10 idle after reset", res_none_o, 0);

        // R1: single port 13 sits in column 1, row 5
        run(64'h1 << 13, rd_all(0), cd_all(0), 0, 0, "R1 single port");

        // R3 / R6: full mask, equal depths, pointer rotation
        for (int i = 0; i < 4; i++) begin
            run('1, rd_all(0), cd_all(0), 0, 0, "R3 R6 rotate");
        end

        // R2: only column 5 below half
        rd = rd_all(12);
        rd[5*5 +: 5] = 5'd7;
        run('1, rd, cd_all(0), 0, 0, "R2 prefer uncongested");

        // R2: all congested -> plain round robin
        run('1, rd_all(16), cd_all(0), 0, 0, "R2 all congested");

        // R5: class ordering inside a column
        cd = cd_all(9);
        cd[2*4 +: 4] = 4'd5;
        cd[6*4 +: 4] = 4'd3;
        run('1, rd_all(0), cd, 0, 0, "R5 almost empty wins");
        cd[6*4 +: 4] = 4'd10;
        run('1, rd_all(0), cd, 0, 0, "R5 half over full");
        run(64'h00FF_0000_0000_0000, rd_all(0), cd_all(10), 0, 0, "R5 all full");

        // R11: wide column vs narrow column
        run(64'h0000_0001_0000_00FF, rd_all(0), cd_all(0), 0, 0, "R11 port count ignored");
        run(64'h0000_0001_0000_00FF, rd_all(0), cd_all(0), 0, 0, "R11 port count ignored");

        // R8: empty mask
        run('0, rd_all(0), cd_all(0), 0, 0, "R8 empty mask");

        // R7: drop leaves pointers, same request repeats identically
        run('1, rd_all(3), cd_all(1), 1, 0, "R7 dropped");
        run('1, rd_all(3), cd_all(1), 0, 0, "R7 after drop");

        // R9: request during processing ignored
        run(64'h0000_0000_0400_0000, rd_all(0), cd_all(0), 0, 1, "R9 busy request ignored");

        // fairness over a long run (R3)
        for (int c = 0; c < 8; c++) col_hits[c] = 0;
        for (int i = 0; i < 64; i++) run('1, rd_all(2), cd_all(2), 0, 0, "R3 fairness");
        for (int c = 0; c < 8; c++) check(col_hits[c] == 8, "R3 equal column share", col_hits[c], 8);

        // randomized against the model
        for (int i = 0; i < 300; i++) begin
            bit [63:0] m;
            m = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            if (i % 17 == 0) m = '0;
            for (int c = 0; c < 8; c++) rd[c*5 +: 5] = 5'($urandom % 17);
            for (int r = 0; r < 8; r++) cd[r*4 +: 4] = 4'($urandom % 11);
            run(m, rd, cd, (i % 7 == 3), 0, "R2 R5 random");
        end

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R9 scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule